// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general-purpose timer, together with the up-counter that feeds it. The counter runs from zero to an auto-reload limit, wraps to zero and marks that wrap as an update event. A four-bit mode code selects how the channel's reference output reacts to the counter. It can hold its level, set, clear or toggle on a match, be forced low or high, or follow the counter in one of two pulse-width polarities.

Software programs the channel through a narrow write port. An external trigger can start the counter in one-pulse mode. It can also drive the output at once through a fast path, so the first edge of a pulse leaves earlier. The compare value is either applied at once or held in a shadow register until the next update event. A lock level guards the mode fields of a channel that drives an output.

Top module: `tim_oc_channel`

## Requirements
- R1: After reset the reference output, the match flag and the update flag are 0, the counter is 0 and the mode is frozen.
- R2: Write select codes are 0 control word, 1 compare value, 2 auto-reload value, 3 timer setup, 4 counter load. A write takes effect at the clock edge where `wr_en` is high. Setup bit 0 enables counting. While counting, the counter steps by one per clock. After the cycle in which it equals the auto-reload value it becomes 0, and `upd_evt` is high for exactly that one clock.
- R3: `cc_match` is high for one clock after each running cycle in which the counter equals the active compare value, in every mode.
- R4: Mode 0001 sets the reference, 0010 clears it and 0011 toggles it, each on the edge where `cc_match` rises. Mode 0000 and every code above 0111 leave the reference unchanged.
- R5: Mode 0101 drives the reference high and mode 0100 drives it low, from the first edge after the mode is written, regardless of the counter.
- R6: In mode 0110 the reference is high after a cycle in which counter < compare and low otherwise. Mode 0111 gives the opposite level.
- R7: In the two counter-following modes the reference moves only when the less-than result changes, or on the edge after the mode changes from 0000 to one of them. Arriving from any other mode keeps the old level until the comparison changes.
- R8: Control bit 3 enables preload. With preload off, a compare write is active from the next clock. With it on, the write goes to a shadow that becomes active at the wrap edge of an update event.
- R9: Setup bit 1 selects one-pulse mode. With counting enabled, the counter rests until a rising edge of `trig_in` and then runs one period. It stops at 0 after the update event.
- R10: With control bit 2 set in mode 0110 or 0111, a `trig_in` rise first sampled at edge E sets the reference to its after-match level at edge E+2: low for 0110, high for 0111. Without it, the counter starts at E+2 and the first comparison-driven change comes no earlier than E+4.
- R11: Setup bits 3:2 hold a lock level that can be written only while it is 0. While it is 3 and the stored direction field is 00, control word writes are ignored.
- R12: In the control word, mode bit 3 is bit 16, mode bits 2:0 are bits 6:4, and direction is bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| trig_in | input | 1 | External trigger, asynchronous |
| oc_ref | output | 1 | Reference output, active high |
| cc_match | output | 1 | One-clock compare-match flag |
| upd_evt | output | 1 | One-clock update event flag |
| cnt_val | output | CNT_W | Current counter value |

## Verification
The embedded properties check on every cycle that the counter steps by one, that the counter is at zero after an update, and that the forced and frozen modes hold the output. They also check that a locked control write leaves the mode alone, that one-pulse runs stop at the update, and that the fast trigger path lands its compare level. Only the bench's scenarios can show the whole output waveform of each mode over full periods. The same holds for the choice between entering pulse-width mode from frozen and from a forced level, and for the update edge at which a preloaded compare value takes over. The trigger-to-output latency with and without the fast path, and the write-once lock sequence, also need those scenarios.

// File: rtl/tim_oc_channel.sv
`timescale 1ns/1ps
module tim_oc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             trig_in,
  output logic             oc_ref,
  output logic             cc_match,
  output logic             upd_evt,
  output logic [CNT_W-1:0] cnt_val
);
  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_CMP = 3'd1, SEL_ARR = 3'd2,
                         SEL_SETUP = 3'd3, SEL_LOAD = 3'd4;
  localparam logic [3:0] M_FROZEN = 4'd0, M_SET = 4'd1, M_CLR = 4'd2, M_TOG = 4'd3,
                         M_LOW = 4'd4, M_HIGH = 4'd5, M_PWM1 = 4'd6, M_PWM2 = 4'd7;

  logic [3:0]       mode_q, mode_prev;
  logic             pe_q, fe_q, cen_q, opm_q, run_q;
  logic [1:0]       dir_q, lock_q;
  logic [CNT_W-1:0] arr_q, cmp_sh, cmp_act, cnt_q;
  logic             t1, t2, t3, lt_q, oc_q, match_q, upd_q, oc_d;
  logic             unused_hi;

  assign unused_hi = ^wr_data[31:17];

  wire wr_ctrl   = wr_en && wr_sel == SEL_CTRL;
  wire wr_load   = wr_en && wr_sel == SEL_LOAD;
  wire locked    = lock_q == 2'b11 && dir_q == 2'b00;
  wire running   = cen_q && (!opm_q || run_q);
  wire upd_c     = running && cnt_q == arr_q;
  wire match_c   = running && cnt_q == cmp_act;
  wire lt        = cnt_q < cmp_act;
  wire trig_edge = t2 && !t3;
  wire is_pwm    = mode_q == M_PWM1 || mode_q == M_PWM2;
  wire pwm_lvl   = (mode_q == M_PWM1) ? lt : !lt;
  wire fast_hit  = fe_q && is_pwm && trig_edge;

  // control word, setup and auto-reload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_FROZEN; pe_q <= 1'b0; fe_q <= 1'b0; dir_q <= 2'b00;
      cen_q <= 1'b0; opm_q <= 1'b0; lock_q <= 2'b00; arr_q <= '1;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTRL: if (!locked) begin
          mode_q <= {wr_data[16], wr_data[6:4]};
          pe_q   <= wr_data[3];
          fe_q   <= wr_data[2];
          dir_q  <= wr_data[1:0];
        end
        SEL_ARR: arr_q <= wr_data[CNT_W-1:0];
        SEL_SETUP: begin
          cen_q <= wr_data[0];
          opm_q <= wr_data[1];
          if (lock_q == 2'b00) lock_q <= wr_data[3:2];
        end
        default: ;
      endcase
    end
  end

  // compare value with optional shadow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_sh <= '0; cmp_act <= '0;
    end else if (wr_en && wr_sel == SEL_CMP) begin
      cmp_sh <= wr_data[CNT_W-1:0];
      if (!pe_q) cmp_act <= wr_data[CNT_W-1:0];
      else if (upd_c) cmp_act <= cmp_sh;
    end else if (upd_c && pe_q) begin
      cmp_act <= cmp_sh;
    end
  end

  // trigger synchroniser and counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1 <= 1'b0; t2 <= 1'b0; t3 <= 1'b0;
      cnt_q <= '0; run_q <= 1'b0; upd_q <= 1'b0;
    end else begin
      t1 <= trig_in; t2 <= t1; t3 <= t2;
      upd_q <= upd_c;
      if (wr_load) cnt_q <= wr_data[CNT_W-1:0];
      else if (running) cnt_q <= upd_c ? '0 : cnt_q + 1'b1;
      if (upd_c) run_q <= 1'b0;
      else if (trig_edge && cen_q && opm_q) run_q <= 1'b1;
    end
  end

  always_comb begin
    oc_d = oc_q;
    case (mode_q)
      M_SET:  if (match_c) oc_d = 1'b1;
      M_CLR:  if (match_c) oc_d = 1'b0;
      M_TOG:  if (match_c) oc_d = !oc_q;
      M_LOW:  oc_d = 1'b0;
      M_HIGH: oc_d = 1'b1;
      M_PWM1, M_PWM2: begin
        if (fast_hit) oc_d = (mode_q == M_PWM2);
        else if (mode_prev == M_FROZEN || lt != lt_q) oc_d = pwm_lvl;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q <= 1'b0; match_q <= 1'b0; lt_q <= 1'b0; mode_prev <= M_FROZEN;
    end else begin
      oc_q <= oc_d; match_q <= match_c; lt_q <= lt; mode_prev <= mode_q;
    end
  end

  assign oc_ref   = oc_q;
  assign cc_match = match_q;
  assign upd_evt  = upd_q;
  assign cnt_val  = cnt_q;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_q != arr_q && !wr_load) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R2
  upd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (cnt_q == '0 || $past(wr_load)));
  // R3
  match_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_match |-> $past(running));
  // R4
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FROZEN) |=> $stable(oc_q));
  // R5
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HIGH) |=> oc_q);
  // R5
  force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_LOW) |=> !oc_q);
  // R9
  opm_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_c |=> !run_q);
  // R10
  fast_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && mode_q == M_PWM2 && trig_edge) |=> oc_q);
  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_ctrl) |=> $stable(mode_q));
endmodule

// File: tb/sim_tim_oc_channel.sv
`timescale 1ns/1ps
module sim_tim_oc_channel;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, trig_in = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic oc_ref, cc_match, upd_evt;
  logic [15:0] cnt_val;

  always #2.5 clk = ~clk;

  tim_oc_channel #(.CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .trig_in(trig_in), .oc_ref(oc_ref), .cc_match(cc_match), .upd_evt(upd_evt),
    .cnt_val(cnt_val));

  typedef struct { int due; string req; int sig; int exp; } item_t;
  item_t q[$];
  int cyc = 0, total = 0, bad = 0;
  bit done = 1'b0;
  string names[4] = '{"oc_ref", "cc_match", "upd_evt", "cnt_val"};

  function automatic int obs(int s);
    case (s)
      0: return int'(oc_ref);
      1: return int'(cc_match);
      2: return int'(upd_evt);
      default: return int'(cnt_val);
    endcase
  endfunction

  // monitor: compares due items just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        total++;
        if (obs(q[i].sig) != q[i].exp) begin
          bad++;
          $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d",
                   q[i].req, names[q[i].sig], cyc, obs(q[i].sig), q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic tick(int n = 1); repeat (n) @(negedge clk); endtask
  task automatic wr(int sel, logic [31:0] d);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d; tick(); wr_en = 1'b0;
  endtask
  task automatic expect_at(string r, int s, int o, int v);
    item_t it;
    it.due = cyc + o; it.req = r; it.sig = s; it.exp = v;
    q.push_back(it);
  endtask
  task automatic drain(); while (q.size() > 0) tick(); endtask

  function automatic logic [31:0] cw(int mode, int pe = 0, int fe = 0, int dir = 0);
    return (32'(mode >> 3 & 1) << 16) | (32'(mode & 7) << 4) | (32'(pe) << 3) |
           (32'(fe) << 2) | 32'(dir & 3);
  endfunction
  function automatic logic [31:0] cf(int cen, int opm, int lock);
    return 32'(cen) | (32'(opm) << 1) | (32'(lock & 3) << 2);
  endfunction

  task automatic setup(int arr, int cmp, logic [31:0] ctrl);
    wr(3, cf(0, 0, 0)); wr(4, 0); wr(2, 32'(arr));
    wr(0, cw(0)); wr(1, 32'(cmp)); wr(0, ctrl);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_at("R1", 0, 1, 0); expect_at("R1", 1, 1, 0);
    expect_at("R1", 2, 1, 0); expect_at("R1", 3, 1, 0);
    tick(2);

    // R2 R3 counting, wrap, match in frozen mode
    setup(4, 2, cw(0));
    wr(3, cf(1, 0, 0));
    for (int o = 1; o <= 10; o++) begin
      expect_at("R2", 3, o, o % 5);
      expect_at("R2", 2, o, (o % 5 == 0) ? 1 : 0);
      expect_at("R3", 1, o, (o % 5 == 3) ? 1 : 0);
      expect_at("R4", 0, o, 0);
    end
    tick(11); drain();

    // R4 set, clear, toggle on match
    setup(4, 1, cw(1)); wr(3, cf(1, 0, 0));
    expect_at("R4", 0, 1, 0); expect_at("R4", 0, 2, 1); expect_at("R4", 0, 6, 1);
    tick(7); drain();
    setup(4, 1, cw(2)); wr(3, cf(1, 0, 0));
    expect_at("R4", 0, 1, 1); expect_at("R4", 0, 2, 0);
    tick(4); drain();
    setup(4, 1, cw(3)); wr(3, cf(1, 0, 0));
    expect_at("R4", 0, 2, 1); expect_at("R4", 0, 6, 1);
    expect_at("R4", 0, 7, 0); expect_at("R4", 0, 12, 1);
    tick(13); drain();

    // R5 forced levels, R12 reserved code 1101 uses bit 16
    wr(3, cf(0, 0, 0));
    wr(0, cw(5)); expect_at("R5", 0, 1, 1); tick(2);
    wr(0, cw(4)); expect_at("R5", 0, 1, 0); tick(2);
    wr(0, cw(13)); expect_at("R12", 0, 1, 0); expect_at("R4", 0, 3, 0);
    tick(4); drain();

    // R6 both counter-following polarities
    setup(4, 2, cw(6)); expect_at("R7", 0, 1, 1); tick(1);
    wr(3, cf(1, 0, 0));
    for (int o = 1; o <= 10; o++) expect_at("R6", 0, o, (((o - 1) % 5) < 2) ? 1 : 0);
    tick(11); drain();
    setup(4, 2, cw(7)); expect_at("R7", 0, 1, 0); tick(1);
    wr(3, cf(1, 0, 0));
    for (int o = 1; o <= 10; o++) expect_at("R6", 0, o, (((o - 1) % 5) < 2) ? 0 : 1);
    tick(11); drain();

    // R7 entering from a forced level keeps the level until comparison changes
    wr(3, cf(0, 0, 0)); wr(4, 0); wr(2, 5); wr(0, cw(0)); wr(1, 3);
    wr(0, cw(4)); wr(0, cw(6));
    expect_at("R7", 0, 1, 0); expect_at("R7", 0, 2, 0); tick(2);
    wr(3, cf(1, 0, 0));
    for (int o = 1; o <= 6; o++) expect_at("R7", 0, o, 0);
    expect_at("R7", 0, 7, 1);
    tick(8); drain();

    // R8 immediate compare write, then shadowed write
    setup(9, 2, cw(0)); wr(1, 5); wr(3, cf(1, 0, 0));
    expect_at("R8", 1, 3, 0); expect_at("R8", 1, 6, 1);
    tick(7); drain();
    setup(9, 2, cw(0)); wr(0, cw(0, 1)); wr(1, 7); wr(3, cf(1, 0, 0));
    expect_at("R8", 1, 3, 1); expect_at("R8", 1, 8, 0); expect_at("R2", 2, 10, 1);
    expect_at("R8", 1, 13, 0); expect_at("R8", 1, 18, 1);
    tick(19); drain();

    // R9 one-pulse run started by trigger
    setup(3, 0, cw(0)); wr(3, cf(1, 1, 0));
    expect_at("R9", 3, 1, 0); expect_at("R9", 3, 3, 0);
    tick(3);
    trig_in = 1'b1;
    expect_at("R9", 3, 3, 0); expect_at("R9", 3, 4, 1); expect_at("R9", 3, 6, 3);
    expect_at("R9", 3, 7, 0); expect_at("R9", 2, 7, 1); expect_at("R9", 3, 10, 0);
    tick(11); trig_in = 1'b0; tick(3); drain();

    // R10 fast trigger path, then normal path
    setup(5, 3, cw(7, 0, 1)); wr(3, cf(1, 1, 0)); tick(2);
    trig_in = 1'b1;
    expect_at("R10", 0, 2, 0); expect_at("R10", 0, 3, 1);
    expect_at("R10", 0, 6, 1); expect_at("R10", 0, 10, 0);
    tick(12); trig_in = 1'b0; tick(3); drain();
    wr(0, cw(7)); tick(2);
    trig_in = 1'b1;
    expect_at("R10", 0, 3, 0); expect_at("R10", 0, 6, 0);
    expect_at("R10", 0, 7, 1); expect_at("R10", 0, 10, 0);
    tick(12); trig_in = 1'b0; tick(3); drain();

    // R11 lock: non-output channel writable, output channel blocked, lock sticky
    wr(3, cf(0, 0, 0));
    wr(0, cw(4, 0, 0, 1)); expect_at("R11", 0, 1, 0); tick(1);
    wr(3, cf(0, 0, 3));
    wr(0, cw(5)); expect_at("R11", 0, 1, 1); tick(2);
    wr(0, cw(4)); expect_at("R11", 0, 1, 1); expect_at("R11", 0, 3, 1); tick(4);
    wr(3, cf(0, 0, 0));
    wr(0, cw(4)); expect_at("R11", 0, 1, 1); expect_at("R11", 0, 3, 1);
    tick(4); drain();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule